// File: doc/BRIEF.md
# Pulse-Swallow Divider Control

This block holds the counters of a programmable frequency divider that works with a 16/17 dual-modulus prescaler. It runs on the prescaler output. It also sends a modulus-select line back to the prescaler. A 15-bit ratio word is split into a main count M (upper eleven bits) and a swallow count A (lower four bits).

At the start of each division cycle, both counters load from the ratio word. For the first A prescaler periods the prescaler is told to divide by 17. For the remaining M−A periods it divides by 16. The total is 16·M + A prescaler input clocks per output pulse.

A ratio whose main count is zero or smaller than its swallow count cannot be met, and the block flags it. A half-rate copy of the division cycle can be routed to a test output.

Top module: `pulse_swallow_div`

## Requirements
- R1: With M = ratio_i[14:4] and A = ratio_i[3:0], 1 ≤ M and A ≤ M, successive cycle-starting edges of clk_i are exactly 16·M + A prescaler input clocks apart.
- R2: mod17_o is high for the first A clk_i periods of each division cycle and low for the remaining M−A. With A = 0 it never rises.
- R3: div_pulse_o is high during the clk_i period that follows the edge completing a division cycle, and low during the other periods of the cycle.
- R4: ratio_i is sampled only at the edge that completes a cycle. A change at any other time alters neither the length nor the modulus pattern of the cycle in progress.
- R5: ratio_bad_o is high throughout a cycle whose loaded ratio has M = 0 or M < A, and low for a legal ratio. It changes only at the cycle-completing edge.
- R6: A half-rate state toggles at each cycle-completing edge. test_o shows it while test_en_i is high and is low while test_en_i is low.
- R7: While rst_ni is low, mod17_o, div_pulse_o, ratio_bad_o and test_o are all low. The first clk_i edge after release loads ratio_i and starts a cycle with a pulse.
- R8: At the smallest legal M (M = A), every prescaler period of the cycle uses divide-by-17. With M = 1, every clk_i edge completes a cycle, so div_pulse_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 15 | Division ratio word, {M, A} |
| test_en_i | input | 1 | Routes the half-rate signal to test_o |
| mod17_o | output | 1 | Modulus select to the prescaler, 1 = divide by 17 |
| div_pulse_o | output | 1 | One clk_i period per division cycle |
| ratio_bad_o | output | 1 | Loaded ratio has M = 0 or M < A |
| test_o | output | 1 | Half-rate division output when enabled |

## Verification
The bench builds the block with its default widths: an 11-bit main count and a 4-bit swallow count. A behavioural prescaler drives it from a 250 MHz input clock.

These widths bring several cases within reach in a short run:
- ratios from 16 up to several thousand;
- the full swallow range up to A = 15 at its smallest legal M;
- the M = 1 case, where every edge reloads;
- both kinds of illegal word.

The period measured in prescaler input clocks confirms that the modulus feedback and the reload timing work together.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;
  localparam int unsigned PSD_M_W = 11;
  localparam int unsigned PSD_A_W = 4;

  typedef enum logic {
    MOD_DIV16 = 1'b0,
    MOD_DIV17 = 1'b1
  } psd_mod_e;
endpackage

// File: rtl/psd_main_cnt.sv
`timescale 1ns/1ps
module psd_main_cnt
  import psd_pkg::*;
#(
  parameter int unsigned M_W = PSD_M_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_load_i,
  output logic           last_o,
  output logic [M_W-1:0] m_cnt_o
);
  logic [M_W-1:0] m_q;

  // remaining periods <= 1: this edge closes the cycle (0 only after reset or M=0)
  assign last_o  = ~|m_q[M_W-1:1];
  assign m_cnt_o = m_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
    end else if (last_o) begin
      m_q <= m_load_i;
    end else begin
      m_q <= m_q - 1'b1;
    end
  end
endmodule

// File: rtl/psd_swallow_cnt.sv
`timescale 1ns/1ps
module psd_swallow_cnt
  import psd_pkg::*;
#(
  parameter int unsigned A_W = PSD_A_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reload_i,
  input  logic [A_W-1:0] a_load_i,
  output logic           mod17_o,
  output logic [A_W-1:0] a_cnt_o
);
  logic [A_W-1:0] a_q;
  psd_mod_e       mod_sel;

  always_comb mod_sel = (|a_q) ? MOD_DIV17 : MOD_DIV16;

  assign mod17_o = (mod_sel == MOD_DIV17);
  assign a_cnt_o = a_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
    end else if (reload_i) begin
      a_q <= a_load_i;
    end else if (mod_sel == MOD_DIV17) begin
      a_q <= a_q - 1'b1;
    end
  end
endmodule

// File: rtl/psd_test_out.sv
`timescale 1ns/1ps
module psd_test_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic test_en_i,
  output logic test_o
);
  logic half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
    end else if (toggle_i) begin
      half_q <= ~half_q;
    end
  end

  assign test_o = test_en_i & half_q;
endmodule

// File: rtl/pulse_swallow_div.sv
`timescale 1ns/1ps
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter  int unsigned M_W = PSD_M_W,
  parameter  int unsigned A_W = PSD_A_W,
  localparam int unsigned N_W = M_W + A_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N_W-1:0] ratio_i,
  input  logic           test_en_i,
  output logic           mod17_o,
  output logic           div_pulse_o,
  output logic           ratio_bad_o,
  output logic           test_o
);
  logic [M_W-1:0] m_new;
  logic [A_W-1:0] a_new;
  logic [M_W-1:0] a_ext;
  logic [M_W-1:0] m_cnt;
  logic [A_W-1:0] a_cnt;
  logic           last;
  logic           bad_q;
  logic           pulse_q;

  assign m_new = ratio_i[N_W-1:A_W];
  assign a_new = ratio_i[A_W-1:0];
  assign a_ext = {{(M_W-A_W){1'b0}}, a_new};

  psd_main_cnt #(.M_W(M_W)) u_main (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .m_load_i (m_new),
    .last_o   (last),
    .m_cnt_o  (m_cnt)
  );

  psd_swallow_cnt #(.A_W(A_W)) u_swallow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .reload_i (last),
    .a_load_i (a_new),
    .mod17_o  (mod17_o),
    .a_cnt_o  (a_cnt)
  );

  psd_test_out u_test (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .toggle_i  (last),
    .test_en_i (test_en_i),
    .test_o    (test_o)
  );

  // legality and pulse are taken with the ratio at the reload edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bad_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= last;
      if (last) begin
        bad_q <= (m_new == '0) || (m_new < a_ext);
      end
    end
  end

  assign div_pulse_o = pulse_q;
  assign ratio_bad_o = bad_q;
endmodule

// File: rtl/psd_checker.sv
`timescale 1ns/1ps
module psd_checker #(
  parameter int unsigned M_W = 11,
  parameter int unsigned A_W = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           last_i,
  input logic [M_W-1:0] m_cnt_i,
  input logic [A_W-1:0] a_cnt_i,
  input logic           mod17_i,
  input logic           div_pulse_i,
  input logic           ratio_bad_i,
  input logic           test_en_i,
  input logic           test_i
);
  AST_MOD_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mod17_i && !last_i) |=> !mod17_i); // R2

  AST_SWALLOW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod17_i && !last_i) |=> ($past(a_cnt_i) == a_cnt_i + {{(A_W-1){1'b0}}, 1'b1})); // R2

  AST_PULSE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_i && (|m_cnt_i[M_W-1:1])) |=> !div_pulse_i); // R3

  AST_BAD_AT_RELOAD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_pulse_i |-> $stable(ratio_bad_i)); // R5

  AST_SWALLOW_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_pulse_i && !ratio_bad_i) |-> ({{(M_W-A_W){1'b0}}, a_cnt_i} <= m_cnt_i)); // R1

  AST_TEST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && $past(test_en_i) && !div_pulse_i) |-> $stable(test_i)); // R6
endmodule

bind pulse_swallow_div psd_checker #(.M_W(M_W), .A_W(A_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .last_i      (last),
  .m_cnt_i     (m_cnt),
  .a_cnt_i     (a_cnt),
  .mod17_i     (mod17_o),
  .div_pulse_i (div_pulse_o),
  .ratio_bad_i (ratio_bad_o),
  .test_en_i   (test_en_i),
  .test_i      (test_o)
);

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module psd_prescaler_model (
  input  logic fclk_i,
  input  logic rst_ni,
  input  logic mod17_i,
  output logic pclk_o
);
  int pc;
  int len;

  // len is taken one input clock after the output edge, once mod17 has settled
  always @(posedge fclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc     <= 15;
      len    <= 16;
      pclk_o <= 1'b0;
    end else begin
      if (pc >= len - 1) begin
        pc     <= 0;
        pclk_o <= 1'b1;
      end else begin
        pc     <= pc + 1;
        pclk_o <= (pc + 1 < 8);
      end
      if (pc == 0) len <= mod17_i ? 17 : 16;
    end
  end
endmodule

module pulse_swallow_div_test;
  localparam int M_W = 11;
  localparam int A_W = 4;
  localparam int N_W = M_W + A_W;

  logic           fclk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N_W-1:0] ratio = {11'd5, 4'd3};
  logic           test_en = 1'b1;
  logic           pclk;
  logic           mod17;
  logic           div_pulse;
  logic           bad;
  logic           tst;

  always #2 fclk = ~fclk;

  psd_prescaler_model u_pre (
    .fclk_i (fclk),
    .rst_ni (rst_n),
    .mod17_i(mod17),
    .pclk_o (pclk)
  );

  pulse_swallow_div uut (
    .clk_i       (pclk),
    .rst_ni      (rst_n),
    .ratio_i     (ratio),
    .test_en_i   (test_en),
    .mod17_o     (mod17),
    .div_pulse_o (div_pulse),
    .ratio_bad_o (bad),
    .test_o      (tst)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: one queue entry per prescaler period, holding its modulus
  bit     q[$];
  bit     exp_mod, exp_pulse, exp_bad, exp_half;
  bit     pclk_d;
  bit     have_ref, cfg_ok;
  longint ticks = 0;
  longint last_reload = 0;
  int     cfg_n;
  int     m_s, a_s, n_s;
  event   pev, rev;

  always @(negedge fclk) begin
    ticks++;
    if (!rst_n) begin
      q.delete();
      exp_half = 1'b0;
      exp_bad  = 1'b0;
      pclk_d   = 1'b0;
      have_ref = 1'b0;
      cfg_ok   = 1'b0;
    end else begin
      if (pclk && !pclk_d) begin
        if (q.size() == 0) begin
          m_s = int'(ratio[N_W-1:A_W]);
          a_s = int'(ratio[A_W-1:0]);
          if (have_ref && cfg_ok)
            chk(ticks - last_reload == longint'(cfg_n), "R1 R4", "period",
                int'(ticks - last_reload), cfg_n);
          have_ref    = 1'b1;
          last_reload = ticks;
          cfg_ok      = (m_s != 0) && (m_s >= a_s);
          cfg_n       = 16 * m_s + a_s;
          exp_bad     = !cfg_ok;
          exp_half    = !exp_half;
          exp_pulse   = 1'b1;
          n_s = (m_s == 0) ? 1 : m_s;
          for (int i = 0; i < n_s; i++) q.push_back(i < a_s);
          ->rev;
        end else begin
          exp_pulse = 1'b0;
        end
        exp_mod = q.pop_front();
        if (cfg_ok) chk(mod17 == exp_mod, "R2", "mod17", int'(mod17), int'(exp_mod));
        chk(div_pulse == exp_pulse, "R3", "div_pulse", int'(div_pulse), int'(exp_pulse));
        chk(bad == exp_bad, "R5", "ratio_bad", int'(bad), int'(exp_bad));
        chk(tst == (test_en & exp_half), "R6", "test", int'(tst), int'(test_en & exp_half));
        ->pev;
      end
      pclk_d = pclk;
    end
  end

  task automatic wait_rel(input int n);
    repeat (n) @(rev);
  endtask

  task automatic set_ratio(input int m, input int a);
    #1 ratio = {M_W'(m), A_W'(a)};
  endtask

  initial begin
    #10;
    chk(mod17 == 1'b0, "R7", "reset mod17", int'(mod17), 0);
    chk(div_pulse == 1'b0, "R7", "reset div_pulse", int'(div_pulse), 0);
    chk(bad == 1'b0, "R7", "reset ratio_bad", int'(bad), 0);
    chk(tst == 1'b0, "R7", "reset test", int'(tst), 0);
    @(negedge fclk);
    #1 rst_n = 1'b1;
    @(rev);
    chk(div_pulse == 1'b1, "R7", "first edge pulse", int'(div_pulse), 1);
    wait_rel(3);

    set_ratio(10, 0); wait_rel(4);
    test_en = 1'b0;
    set_ratio(15, 15); wait_rel(4);   // R8 smallest legal M for A=15

    set_ratio(1, 0); wait_rel(2);
    for (int i = 0; i < 6; i++) begin
      @(pev);
      chk(div_pulse == 1'b1, "R8", "M=1 pulse held", int'(div_pulse), 1);
    end
    set_ratio(1, 1); wait_rel(2);
    for (int i = 0; i < 6; i++) begin
      @(pev);
      chk(div_pulse == 1'b1 && mod17 == 1'b1, "R8", "M=A=1 pulse and mod17",
          int'({div_pulse, mod17}), 3);
    end
    wait_rel(2);

    // R4: change the word mid-cycle; the running cycle keeps the old length
    set_ratio(40, 6); wait_rel(2);
    repeat (10) @(pev);
    set_ratio(7, 2);
    wait_rel(1);
    wait_rel(3);

    test_en = 1'b1;
    set_ratio(300, 9); wait_rel(3);

    set_ratio(3, 7); wait_rel(2);
    @(pev);
    chk(bad == 1'b1, "R5", "M<A flagged", int'(bad), 1);
    set_ratio(0, 5); wait_rel(3);
    @(pev);
    chk(bad == 1'b1, "R5", "M=0 flagged", int'(bad), 1);
    set_ratio(2, 2); wait_rel(3);
    @(pev);
    chk(bad == 1'b0, "R5", "legal clears flag", int'(bad), 0);
    test_en = 1'b0;
    wait_rel(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge fclk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule